// File: doc/BRIEF.md
# Reset Vector Table Locator

This block runs once per start pulse, normally right after reset, to find where a processor's boot vectors live in a byte-wide ROM. It reads the ROM through a simple read port: it drives an address and takes the byte back one cycle later. When it finishes it presents a 32-bit initial stack pointer, a 32-bit initial program counter and a done flag.

Two layouts are supported, chosen by a mode input that is sampled at start. In the fixed layout the vectors sit at the bottom of the ROM. In the searched layout the block walks upward one byte per cycle from a fixed scan origin. It looks for a run of four bytes that all hold 0xCC, and the vector table begins immediately after that run. The offset of the table from the scan origin is reported. A failed search ends with a not-found flag.

Top module: `rvl_locator`

## Requirements
- R1: A start pulse is accepted only while the block is idle or finished, and done reads 0 in the cycle after an accepted start. A start pulse while a search or fetch is in progress is ignored, and so is any change of the mode input at that time.
- R2: With flash_mode=1 at start, the ROM is read from byte address 0x12000 upward, one address per read, up to and including the last ROM byte. Bytes below 0x12000 never take part in a match, so a 0xCC run that begins below 0x12000 is not found.
- R3: The marker is the first run of four consecutive addresses that all read 0xCC. The table starts at the address right after the fourth byte of that run. A run of three 0xCC bytes followed by any other value is not a marker. In a run of five 0xCC bytes, the fifth byte is the first byte of the table.
- R4: stack_ptr is the four table bytes at table+0..table+3 taken big-endian: the byte at table+0 becomes bits 31:24.
- R5: prog_ctr is the four bytes at table+4..table+7, assembled in the same big-endian order.
- R6: With flash_mode=0 at start, no search takes place. stack_ptr comes from bytes 0..3, prog_ctr comes from bytes 4..7, and table_off reads 0.
- R7: After a successful search, table_off equals the table's byte address minus 0x12000. A marker that ends on the last ROM bytes but one still gives a valid table, for example a table that fills the final 8 bytes.
- R8: If the last ROM byte is read without a marker, done and not_found both read 1, and stack_ptr, prog_ctr and table_off all read 0. The next accepted start clears not_found.
- R9: Once done is 1, done, not_found, stack_ptr, prog_ctr and table_off hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins an operation |
| flash_mode | input | 1 | 1: search for the marker; 0: vectors at address 0 |
| rom_addr | output | ADDR_W | ROM byte address |
| rom_data | input | 8 | ROM byte, valid one cycle after its address |
| done | output | 1 | Operation finished, results valid |
| not_found | output | 1 | Search reached the ROM end without a marker |
| stack_ptr | output | 8*VEC_BYTES | Initial stack pointer |
| prog_ctr | output | 8*VEC_BYTES | Initial program counter |
| table_off | output | ADDR_W | Table address minus the scan origin |

## Verification
The hardest situations to reach are the marker edge cases: runs that overlap the scan origin, a five-byte run whose last 0xCC belongs to the table, a broken three-byte run, and a table packed against the top of the ROM. Ordinary ROM contents almost never produce these. The bench therefore models the ROM as a filler pattern that can never equal 0xCC, with a short overlay list of placed bytes for each scenario. It runs with a 128 KiB ROM, so a full miss scan, which walks about 57k addresses, stays short. A start pulse with the opposite mode is injected in the middle of a scan to show that it changes nothing.

// File: rtl/rvl_pkg.sv
package rvl_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SCAN  = 2'd1,
      ST_FETCH = 2'd2,
      ST_DONE  = 2'd3
   } rvl_state_e;
endpackage

// File: rtl/rvl_addr_gen.sv
// Read address counter with a one-cycle read pipeline tag.
module rvl_addr_gen #(
   parameter int ADDR_W = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step,
   output logic [ADDR_W-1:0] addr_q,
   output logic              at_last,
   output logic              rd_vld,
   output logic [ADDR_W-1:0] rd_addr
);
   localparam logic [ADDR_W-1:0] LAST_A = {ADDR_W{1'b1}};

   assign at_last = (addr_q == LAST_A);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         rd_vld  <= 1'b0;
         rd_addr <= '0;
      end else begin
         // a load discards any read still in flight
         rd_vld <= step && !load;
         if (step) rd_addr <= addr_q;
         if (load)
            addr_q <= load_val;
         else if (step && !at_last)
            addr_q <= addr_q + 1'b1;
      end
   end
endmodule

// File: rtl/rvl_marker_window.sv
// Sliding match window: stores one equality flag per earlier byte.
module rvl_marker_window #(
   parameter int          MARKER_LEN  = 4,
   parameter logic [7:0]  MARKER_BYTE = 8'hCC
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       shift,
   input  logic [7:0] byte_in,
   output logic       hit
);
   logic eq_now;
   assign eq_now = (byte_in == MARKER_BYTE);

   generate
      if (MARKER_LEN == 1) begin : g_single
         assign hit = shift && eq_now;
      end else begin : g_multi
         logic [MARKER_LEN-2:0] flags;
         logic [MARKER_LEN-1:0] nxt;
         assign nxt = {flags, eq_now};
         assign hit = shift && eq_now && (&flags);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               flags <= '0;
            else if (clear)
               flags <= '0;
            else if (shift)
               flags <= nxt[MARKER_LEN-2:0];
         end
      end
   endgenerate
endmodule

// File: rtl/rvl_word_asm.sv
// Big-endian assembly of two consecutive words from a byte stream.
module rvl_word_asm #(
   parameter int VEC_BYTES = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clear,
   input  logic                   shift,
   input  logic [7:0]             byte_in,
   output logic [8*VEC_BYTES-1:0] word_hi,
   output logic [8*VEC_BYTES-1:0] word_lo
);
   localparam int W  = 8 * VEC_BYTES;
   localparam int SW = 2 * W;

   logic [SW-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sh <= '0;
      else if (clear)
         sh <= '0;
      else if (shift)
         sh <= {sh[SW-9:0], byte_in};
   end

   assign word_hi = sh[SW-1:W];
   assign word_lo = sh[W-1:0];
endmodule

// File: rtl/rvl_locator.sv
module rvl_locator #(
   parameter int          ADDR_W      = 21,
   parameter int          SCAN_START  = 32'h0001_2000,
   parameter int          MARKER_LEN  = 4,
   parameter logic [7:0]  MARKER_BYTE = 8'hCC,
   parameter int          VEC_BYTES   = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic                   flash_mode,
   output logic [ADDR_W-1:0]      rom_addr,
   input  logic [7:0]             rom_data,
   output logic                   done,
   output logic                   not_found,
   output logic [8*VEC_BYTES-1:0] stack_ptr,
   output logic [8*VEC_BYTES-1:0] prog_ctr,
   output logic [ADDR_W-1:0]      table_off
);
   import rvl_pkg::*;

   localparam int                FETCH_N = 2 * VEC_BYTES;
   localparam int                CNT_W   = $clog2(FETCH_N + 1);
   localparam logic [ADDR_W-1:0] START_A = ADDR_W'(SCAN_START);
   localparam logic [CNT_W-1:0]  FETCH_C = CNT_W'(FETCH_N);
   localparam logic [CNT_W-1:0]  LAST_C  = CNT_W'(FETCH_N - 1);

   generate
      if (ADDR_W < 4 || ADDR_W > 30) begin : g_bad_aw
         $error("rvl_locator: ADDR_W out of range");
      end
      if (SCAN_START < 0 || SCAN_START >= (1 << ADDR_W)) begin : g_bad_start
         $error("rvl_locator: SCAN_START outside ROM");
      end
      if (MARKER_LEN < 1 || VEC_BYTES < 1) begin : g_bad_len
         $error("rvl_locator: MARKER_LEN and VEC_BYTES must be positive");
      end
   endgenerate

   rvl_state_e        state;
   logic              mode_q;
   logic              issued_all;
   logic [CNT_W-1:0]  issue_cnt;
   logic [CNT_W-1:0]  recv_cnt;
   logic              done_q;
   logic              nf_q;
   logic [ADDR_W-1:0] off_q;

   logic              start_ok;
   logic              step;
   logic              load;
   logic [ADDR_W-1:0] load_val;
   logic [ADDR_W-1:0] addr_q;
   logic              at_last;
   logic              rd_vld;
   logic [ADDR_W-1:0] rd_addr;
   logic              win_shift;
   logic              hit;
   logic              scan_hit;
   logic              scan_miss;
   logic              asm_shift;

   assign start_ok  = start && (state == ST_IDLE || state == ST_DONE);
   assign win_shift = (state == ST_SCAN) && rd_vld;
   assign scan_hit  = win_shift && hit;
   assign scan_miss = win_shift && !hit && (rd_addr == {ADDR_W{1'b1}});
   assign asm_shift = (state == ST_FETCH) && rd_vld;

   always_comb begin
      step = 1'b0;
      case (state)
         ST_SCAN:  step = !issued_all;
         ST_FETCH: step = (issue_cnt < FETCH_C);
         default:  step = 1'b0;
      endcase
   end

   always_comb begin
      load     = start_ok || scan_hit;
      load_val = '0;
      if (start_ok)
         load_val = flash_mode ? START_A : '0;
      else if (scan_hit)
         load_val = rd_addr + 1'b1;
   end

   rvl_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .step     (step),
      .addr_q   (addr_q),
      .at_last  (at_last),
      .rd_vld   (rd_vld),
      .rd_addr  (rd_addr)
   );

   rvl_marker_window #(
      .MARKER_LEN  (MARKER_LEN),
      .MARKER_BYTE (MARKER_BYTE)
   ) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (start_ok),
      .shift   (win_shift),
      .byte_in (rom_data),
      .hit     (hit)
   );

   rvl_word_asm #(.VEC_BYTES(VEC_BYTES)) u_asm (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (start_ok),
      .shift   (asm_shift),
      .byte_in (rom_data),
      .word_hi (stack_ptr),
      .word_lo (prog_ctr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         mode_q     <= 1'b0;
         issued_all <= 1'b0;
         issue_cnt  <= '0;
         recv_cnt   <= '0;
         done_q     <= 1'b0;
         nf_q       <= 1'b0;
         off_q      <= '0;
      end else begin
         case (state)
            ST_IDLE, ST_DONE: begin
               if (start_ok) begin
                  done_q     <= 1'b0;
                  nf_q       <= 1'b0;
                  off_q      <= '0;
                  mode_q     <= flash_mode;
                  issued_all <= 1'b0;
                  issue_cnt  <= '0;
                  recv_cnt   <= '0;
                  state      <= flash_mode ? ST_SCAN : ST_FETCH;
               end
            end
            ST_SCAN: begin
               if (step && at_last) issued_all <= 1'b1;
               if (scan_hit) begin
                  off_q     <= rd_addr + 1'b1 - START_A;
                  issue_cnt <= '0;
                  recv_cnt  <= '0;
                  state     <= ST_FETCH;
               end else if (scan_miss) begin
                  nf_q   <= 1'b1;
                  done_q <= 1'b1;
                  state  <= ST_DONE;
               end
            end
            ST_FETCH: begin
               if (step) issue_cnt <= issue_cnt + 1'b1;
               if (rd_vld) begin
                  recv_cnt <= recv_cnt + 1'b1;
                  if (recv_cnt == LAST_C) begin
                     done_q <= 1'b1;
                     state  <= ST_DONE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign rom_addr  = addr_q;
   assign done      = done_q;
   assign not_found = nf_q;
   assign table_off = off_q;
endmodule

// File: rtl/rvl_locator_chk.sv
module rvl_locator_chk #(
   parameter int ADDR_W     = 21,
   parameter int SCAN_START = 32'h0001_2000,
   parameter int VEC_W      = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic                done,
   input logic                not_found,
   input logic [VEC_W-1:0]    stack_ptr,
   input logic [VEC_W-1:0]    prog_ctr,
   input logic [ADDR_W-1:0]   table_off,
   input logic [ADDR_W-1:0]   rom_addr,
   input rvl_pkg::rvl_state_e state,
   input logic                mode_q
);
   import rvl_pkg::*;
   localparam logic [ADDR_W-1:0] START_A = ADDR_W'(SCAN_START);

   a_r1_start_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (state == ST_IDLE || state == ST_DONE)) |=> !done);

   a_r1_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (state == ST_SCAN)) |=> (state != ST_IDLE) && $stable(mode_q));

   a_r2_scan_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SCAN) |-> (rom_addr >= START_A));

   a_r6_fixed_offset_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !mode_q) |-> (table_off == '0) && !not_found);

   a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      not_found |-> done && (stack_ptr == '0) && (prog_ctr == '0) && (table_off == '0));

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done && $stable(stack_ptr) && $stable(prog_ctr)
                           && $stable(table_off) && $stable(not_found));
endmodule

bind rvl_locator rvl_locator_chk #(
   .ADDR_W     (ADDR_W),
   .SCAN_START (SCAN_START),
   .VEC_W      (8*VEC_BYTES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .done      (done),
   .not_found (not_found),
   .stack_ptr (stack_ptr),
   .prog_ctr  (prog_ctr),
   .table_off (table_off),
   .rom_addr  (rom_addr),
   .state     (state),
   .mode_q    (mode_q)
);

// File: tb/tb_rvl_locator.sv
module tb_rvl_locator;
   localparam int AW = 17;
   localparam int NOV = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          flash_mode = 1'b0;
   logic [AW-1:0] rom_addr;
   logic [7:0]    rom_data;
   logic          done, not_found;
   logic [31:0]   stack_ptr, prog_ctr;
   logic [AW-1:0] table_off;

   int n_chk = 0;
   int n_fail = 0;

   logic [AW-1:0] ov_a [NOV];
   logic [7:0]    ov_v [NOV];
   int            ov_n = 0;

   always #5 clk = ~clk;

   rvl_locator #(.ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .flash_mode(flash_mode),
      .rom_addr(rom_addr), .rom_data(rom_data), .done(done),
      .not_found(not_found), .stack_ptr(stack_ptr), .prog_ctr(prog_ctr),
      .table_off(table_off)
   );

   function automatic logic [7:0] rom_byte(input logic [AW-1:0] a);
      logic [7:0] f;
      f = a[7:0] * 8'd7 + 8'd3;
      if (f == 8'hCC) f = 8'h5A;
      for (int i = 0; i < ov_n; i++)
         if (ov_a[i] == a) f = ov_v[i];
      return f;
   endfunction

   always_ff @(posedge clk) rom_data <= rom_byte(rom_addr);

   task automatic chk(input string req, input string what,
                      input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic put(input int a, input logic [7:0] v);
      ov_a[ov_n] = AW'(a);
      ov_v[ov_n] = v;
      ov_n++;
   endtask

   task automatic put_marker(input int a);
      for (int i = 0; i < 4; i++) put(a + i, 8'hCC);
   endtask

   task automatic put_word(input int a, input logic [31:0] w);
      put(a, w[31:24]); put(a + 1, w[23:16]); put(a + 2, w[15:8]); put(a + 3, w[7:0]);
   endtask

   task automatic pulse_start(input logic mode);
      @(negedge clk);
      flash_mode = mode;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int n;
      n = 0;
      while (!done && n < 100000) begin
         @(negedge clk);
         n++;
      end
      if (!done) chk(req, "watchdog", 64'd0, 64'd1);
   endtask

   task automatic run(input string req, input logic mode, input logic [31:0] esp,
                      input logic [31:0] epc, input int eoff, input logic enf);
      pulse_start(mode);
      chk("R1", "done low after start", 64'(done), 64'd0);
      wait_done(req);
      chk(req, "not_found", 64'(not_found), 64'(enf));
      chk(req, "stack_ptr", 64'(stack_ptr), 64'(esp));
      chk(req, "prog_ctr", 64'(prog_ctr), 64'(epc));
      chk(req, "table_off", 64'(table_off), 64'(eoff));
   endtask

   task automatic t_reset();
      chk("R9", "reset done", 64'(done), 64'd0);
      chk("R8", "reset not_found", 64'(not_found), 64'd0);
      chk("R4", "reset stack_ptr", 64'(stack_ptr), 64'd0);
   endtask

   // R6: fixed layout, a marker in the scan region is ignored
   task automatic t_fixed();
      ov_n = 0;
      put_word(0, 32'h1234_5678); put_word(4, 32'h9ABC_DEF0);
      put_marker('h12100); put_word('h12104, 32'hAAAA_0001);
      run("R6", 1'b0, 32'h1234_5678, 32'h9ABC_DEF0, 0, 1'b0);
   endtask

   // R2 R4 R5 R7: plain search
   task automatic t_basic();
      ov_n = 0;
      put_marker('h12400);
      put_word('h12404, 32'h0040_0000); put_word('h12408, 32'h0021_2A4C);
      run("R4", 1'b1, 32'h0040_0000, 32'h0021_2A4C, 'h404, 1'b0);
   endtask

   // R2: runs below or straddling the origin are not matched
   task automatic t_below();
      ov_n = 0;
      put_marker('h11000); put_word('h11004, 32'hDEAD_0000);
      put_marker('h11FFE); put_word('h12002, 32'hDEAD_0001);
      put_marker('h13000);
      put_word('h13004, 32'h0001_1111); put_word('h13008, 32'h0002_2222);
      run("R2", 1'b1, 32'h0001_1111, 32'h0002_2222, 'h1004, 1'b0);
   endtask

   // R3: broken three-byte run, then a five-byte run
   task automatic t_runs();
      ov_n = 0;
      put('h12200, 8'hCC); put('h12201, 8'hCC); put('h12202, 8'hCC); put('h12203, 8'h00);
      put_marker('h12800);
      put_word('h12804, 32'hCC11_2233); put_word('h12808, 32'h4455_6677);
      run("R3", 1'b1, 32'hCC11_2233, 32'h4455_6677, 'h804, 1'b0);
   endtask

   // R7: marker right at the origin
   task automatic t_origin();
      ov_n = 0;
      put_marker('h12000);
      put_word('h12004, 32'h0102_0304); put_word('h12008, 32'h0506_0708);
      run("R7", 1'b1, 32'h0102_0304, 32'h0506_0708, 4, 1'b0);
   endtask

   // R7: table occupies the final eight bytes
   task automatic t_top();
      ov_n = 0;
      put_marker('h1FFF4);
      put_word('h1FFF8, 32'hFEED_FACE); put_word('h1FFFC, 32'hC0FF_EE00);
      run("R7", 1'b1, 32'hFEED_FACE, 32'hC0FF_EE00, 'hDFF8, 1'b0);
   endtask

   // R1: a start in mid scan with the other mode changes nothing
   task automatic t_busy();
      ov_n = 0;
      put_marker('h12600);
      put_word('h12604, 32'h7777_0000); put_word('h12608, 32'h8888_0000);
      put_word(0, 32'h1111_1111); put_word(4, 32'h2222_2222);
      pulse_start(1'b1);
      repeat (20) @(negedge clk);
      pulse_start(1'b0);
      wait_done("R1");
      chk("R1", "busy start sp", 64'(stack_ptr), 64'h7777_0000);
      chk("R1", "busy start pc", 64'(prog_ctr), 64'h8888_0000);
      chk("R1", "busy start off", 64'(table_off), 64'h604);
   endtask

   // R9: results hold
   task automatic t_hold();
      logic [31:0] sp, pc;
      sp = stack_ptr; pc = prog_ctr;
      repeat (50) @(negedge clk);
      chk("R9", "done held", 64'(done), 64'd1);
      chk("R9", "sp held", 64'(stack_ptr), 64'(sp));
      chk("R9", "pc held", 64'(prog_ctr), 64'(pc));
   endtask

   // R8: no marker anywhere, then a restart clears the flag
   task automatic t_miss();
      ov_n = 0;
      put('h1FFFD, 8'hCC); put('h1FFFE, 8'hCC); put('h1FFFF, 8'hCC);
      run("R8", 1'b1, 32'h0, 32'h0, 0, 1'b1);
      put_word(0, 32'hA0A0_A0A0); put_word(4, 32'h0B0B_0B0B);
      run("R8", 1'b0, 32'hA0A0_A0A0, 32'h0B0B_0B0B, 0, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fixed();
      t_basic();
      t_hold();
      t_below();
      t_runs();
      t_origin();
      t_top();
      t_busy();
      t_miss();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule